// File: doc/BRIEF.md
# Fault Injection Wrapper for a Three-Variable AND-XOR Network

The block wraps a small exclusive-OR-of-products network of three data variables and forces a configured fault onto its lines. The network computes F = c2·x1 ⊕ c3·x1·x2 ⊕ c2·zl·x2·x3. Here zl is a separate input that carries the complement of x1. A parity output O is the XOR of all seven primary inputs. The network has twelve lines that can hold a fault: the seven inputs, three AND-gate outputs and two XOR-gate outputs. The last XOR output is F itself.

A configuration register holds one fault description. A testbench or a diagnosis harness loads this register and then applies input vectors. The fault description has a kind, two line indices and two stuck values. There are four kinds of fault: one line stuck at a value, two lines stuck at a time, and a wired-AND or wired-OR bridge between any two lines. Any line can be overridden, but the override always acts at the driver of that line, so every gate that reads the line sees the faulted value. The gate that forms O is never faulted. The harness enumerates the faults and scores fault coverage from the F and O responses; the block does neither.

Top module: `esop_fault_inject`

## Requirements
- R1: With no fault configured (the state after reset), fOut = c2&x1 ^ c3&x1&x2 ^ c2&zl&x2&x3 and oOut is the XOR of x1, x2, x3, c1, c2, c3 and zl. Here x1..x3 are xIn[0..2], c1..c3 are cIn[0..2] and zl is zlIn.
- R2: The line indices are 0–2 for x1–x3, 3–5 for c1–c3 and 6 for zl. Indices 7, 8 and 9 are the AND outputs c2&x1, c3&x1&x2 and c2&zl&x2&x3. Index 10 is the XOR of lines 7 and 8. Index 11 is the XOR of lines 10 and 9, and this line is F.
- R3: cfgKind uses these codes: 0 none, 1 single stuck-at, 2 double stuck-at, 3 AND bridge, 4 OR bridge. The codes 5, 6 and 7 give fault-free behaviour.
- R4: A single stuck-at fault forces line cfgLineA to cfgValA. cfgLineB and cfgValB have no effect.
- R5: A double stuck-at fault forces cfgLineA to cfgValA and cfgLineB to cfgValB. When the two indices are equal, the line takes cfgValA.
- R6: An AND bridge drives both lines to the AND of their fault-free values. Gates downstream of either line use the bridged value.
- R7: An OR bridge drives both lines to the OR of their fault-free values. Gates downstream of either line use the bridged value.
- R8: oOut is the XOR of the possibly faulted lines 0–6. A fault that touches only lines 7–11 leaves oOut unchanged.
- R9: The configuration is loaded only on a rising clock edge with cfgWe high, and it acts from then on. A field change with cfgWe low has no effect. An active-low reset (rstN) clears the configuration to no fault.
- R10: A line index of 12 to 15 selects no line. A stuck-at slot with such an index does nothing. A bridge with such an index does nothing at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rstN | input | 1 | Asynchronous active-low reset; clears the configuration to no fault |
| cfgWe | input | 1 | Loads the fault configuration fields |
| cfgKind | input | 3 | Fault kind code |
| cfgLineA | input | 4 | First line index |
| cfgLineB | input | 4 | Second line index |
| cfgValA | input | 1 | Stuck value for the first line |
| cfgValB | input | 1 | Stuck value for the second line |
| xIn | input | 3 | Data inputs x1 (bit 0) to x3 |
| cIn | input | 3 | Control inputs c1 (bit 0) to c3 |
| zlIn | input | 1 | Complement-of-x1 input |
| fOut | output | 1 | Faulted main output F |
| oOut | output | 1 | Parity output O over the faulted input lines |

## Verification
The bench runs every single stuck-at fault (24), every double stuck-at fault (264), every AND bridge (66) and every OR bridge (66). Each fault gets all 128 input vectors, and the bench compares the outputs against its own line-by-line model.

Some corner cases get extra tests:
- Bridges between a line and a line downstream of it. A design that bridged already-faulted values, instead of fault-free ones, would show a different F.
- Double faults with equal indices. A design where cfgValB wins would return the wrong stuck value.
- Out-of-range indices and the spare kind codes. A design that decoded these loosely would inject a fault on some other line.
- Writes with cfgWe low and a reset after a fault. A register that does not hold its value, or that keeps an old fault, would corrupt fault-free vectors.

// File: rtl/esop_fault_pkg.sv
package esop_fault_pkg;

  // Network shape: primary inputs first, then gate outputs in topological order
  localparam int IN_COUNT   = 7;
  localparam int GATE_COUNT = 5;
  localparam int LINES      = IN_COUNT + GATE_COUNT;
  localparam int IDX_W      = $clog2(LINES + 1) + 1;
  localparam int KIND_W     = 3;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE   = 3'd0,
    FK_SINGLE = 3'd1,
    FK_DOUBLE = 3'd2,
    FK_AND    = 3'd3,
    FK_OR     = 3'd4
  } faultKindE;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [IDX_W-1:0]  lineA;
    logic [IDX_W-1:0]  lineB;
    logic              valA;
    logic              valB;
  } faultCfgT;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LINES-1:0] stuckEn;
    logic [LINES-1:0] stuckVal;
    logic [LINES-1:0] selA;
    logic [LINES-1:0] selB;
    logic             bridgeOr;
  } strobeT;

  // Gate function of line idx given the lines below it
  function automatic logic gateEval(input int idx, input logic [LINES-1:0] lv);
    logic r;
    case (idx)
      7:       r = lv[4] & lv[0];
      8:       r = lv[5] & lv[0] & lv[1];
      9:       r = lv[4] & lv[6] & lv[1] & lv[2];
      10:      r = lv[7] ^ lv[8];
      11:      r = lv[10] ^ lv[9];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/esop_fault_ctrl.sv
module esop_fault_ctrl
  import esop_fault_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [KIND_W-1:0]    cfgKind,
  input  logic [IDX_W-1:0]     cfgLineA,
  input  logic [IDX_W-1:0]     cfgLineB,
  input  logic                 cfgValA,
  input  logic                 cfgValB,
  output strobeT               strobes
);

  faultCfgT cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '{kind: FK_NONE, lineA: '0, lineB: '0, valA: 1'b0, valB: 1'b0};
    end else if (cfgWe) begin
      cfgQ <= '{kind: cfgKind, lineA: cfgLineA, lineB: cfgLineB,
                valA: cfgValA, valB: cfgValB};
    end
  end

  logic [LINES-1:0] hitA;
  logic [LINES-1:0] hitB;

  // One-hot decode; an out-of-range index leaves the mask empty
  for (genvar gi = 0; gi < LINES; gi++) begin : g_decode
    assign hitA[gi] = (cfgQ.lineA == IDX_W'(gi));
    assign hitB[gi] = (cfgQ.lineB == IDX_W'(gi));
  end

  logic bothValid;
  assign bothValid = (|hitA) && (|hitB);

  always_comb begin
    strobes = '0;
    case (cfgQ.kind)
      FK_SINGLE: begin
        strobes.stuckEn  = hitA;
        strobes.stuckVal = cfgQ.valA ? hitA : '0;
      end
      FK_DOUBLE: begin
        // slot A applied last so it wins on equal indices
        for (int i = 0; i < LINES; i++) begin
          if (hitB[i]) begin
            strobes.stuckEn[i]  = 1'b1;
            strobes.stuckVal[i] = cfgQ.valB;
          end
          if (hitA[i]) begin
            strobes.stuckEn[i]  = 1'b1;
            strobes.stuckVal[i] = cfgQ.valA;
          end
        end
      end
      FK_AND, FK_OR: begin
        if (bothValid) begin
          strobes.selA     = hitA;
          strobes.selB     = hitB;
          strobes.bridgeOr = (cfgQ.kind == FK_OR);
        end
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/esop_net_core.sv
module esop_net_core
  import esop_fault_pkg::*;
(
  input  logic [IN_COUNT-1:0] inLines,
  input  strobeT              strobes,
  input  logic                bridgeVal,
  output logic [LINES-1:0]    lines
);

  logic [LINES-1:0] bridgeEn;
  assign bridgeEn = strobes.selA | strobes.selB;

  // Override at each line's driver, in topological order
  always_comb begin
    logic [LINES-1:0] lv;
    lv = '0;
    for (int i = 0; i < IN_COUNT; i++) begin
      lv[i] = strobes.stuckEn[i] ? strobes.stuckVal[i]
            : (bridgeEn[i] ? bridgeVal : inLines[i]);
    end
    for (int i = IN_COUNT; i < LINES; i++) begin
      logic raw;
      raw = gateEval(i, lv);
      lv[i] = strobes.stuckEn[i] ? strobes.stuckVal[i]
            : (bridgeEn[i] ? bridgeVal : raw);
    end
    lines = lv;
  end

endmodule

// File: rtl/esop_fault_dp.sv
module esop_fault_dp
  import esop_fault_pkg::*;
(
  input  logic [IN_COUNT-1:0] inLines,
  input  strobeT              strobes,
  output logic                fOut,
  output logic                oOut
);

  logic [LINES-1:0] freeLines;
  logic [LINES-1:0] faultLines;
  logic             bridgeA;
  logic             bridgeB;
  logic             bridgeVal;

  // Fault-free copy supplies the pre-fault values for bridging
  esop_net_core u_golden (
    .inLines   (inLines),
    .strobes   ('0),
    .bridgeVal (1'b0),
    .lines     (freeLines)
  );

  assign bridgeA   = |(freeLines & strobes.selA);
  assign bridgeB   = |(freeLines & strobes.selB);
  assign bridgeVal = strobes.bridgeOr ? (bridgeA | bridgeB) : (bridgeA & bridgeB);

  esop_net_core u_faulted (
    .inLines   (inLines),
    .strobes   (strobes),
    .bridgeVal (bridgeVal),
    .lines     (faultLines)
  );

  assign fOut = faultLines[LINES-1];
  // Parity gate is fault-free but reads the faulted input lines
  assign oOut = ^faultLines[IN_COUNT-1:0];

endmodule

// File: rtl/esop_fault_inject.sv
module esop_fault_inject
  import esop_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [2:0]  cfgKind,
  input  logic [3:0]  cfgLineA,
  input  logic [3:0]  cfgLineB,
  input  logic        cfgValA,
  input  logic        cfgValB,
  input  logic [2:0]  xIn,
  input  logic [2:0]  cIn,
  input  logic        zlIn,
  output logic        fOut,
  output logic        oOut
);

  strobeT strobes;

  esop_fault_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgKind  (cfgKind),
    .cfgLineA (cfgLineA),
    .cfgLineB (cfgLineB),
    .cfgValA  (cfgValA),
    .cfgValB  (cfgValB),
    .strobes  (strobes)
  );

  esop_fault_dp u_dp (
    .inLines ({zlIn, cIn, xIn}),
    .strobes (strobes),
    .fOut    (fOut),
    .oOut    (oOut)
  );

endmodule

// File: rtl/esop_fault_chk.sv
module esop_fault_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [2:0] cfgKind,
  input logic [3:0] cfgLineA,
  input logic [3:0] cfgLineB,
  input logic       cfgValA,
  input logic       cfgValB,
  input logic [2:0] xIn,
  input logic [2:0] cIn,
  input logic       zlIn,
  input logic       fOut,
  input logic       oOut
);

  logic [2:0] sKind;
  logic [3:0] sA;
  logic [3:0] sB;
  logic       sVA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sKind <= 3'd0;
      sA    <= 4'd0;
      sB    <= 4'd0;
      sVA   <= 1'b0;
    end else if (cfgWe) begin
      sKind <= cfgKind;
      sA    <= cfgLineA;
      sB    <= cfgLineB;
      sVA   <= cfgValA;
    end
  end

  logic refX0;
  logic refF;
  logic refO;
  assign refX0 = (cIn[1] & xIn[0]) ^ (cIn[2] & xIn[0] & xIn[1]);
  assign refF  = refX0 ^ (cIn[1] & zlIn & xIn[1] & xIn[2]);
  assign refO  = ^{xIn, cIn, zlIn};

  // R1 R3
  fault_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind == 3'd0 || sKind > 3'd4) |-> (fOut == refF && oOut == refO));

  // R4
  single_on_f_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind == 3'd1 && sA == 4'd11) |-> (fOut == sVA));

  // R5
  double_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind == 3'd2 && sA == 4'd11 && sB == 4'd11) |-> (fOut == sVA));

  // R6
  and_bridge_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind == 3'd3 && sA == 4'd11 && sB == 4'd10) |-> (fOut == (refF & refX0)));

  // R8
  parity_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind >= 3'd1 && sKind <= 3'd4 && sA >= 4'd7 && (sKind == 3'd1 || sB >= 4'd7))
      |-> (oOut == refO));

  // R10
  range_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sKind == 3'd1 && sA >= 4'd12) |-> (fOut == refF && oOut == refO));

endmodule

bind esop_fault_inject esop_fault_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgKind  (cfgKind),
  .cfgLineA (cfgLineA),
  .cfgLineB (cfgLineB),
  .cfgValA  (cfgValA),
  .cfgValB  (cfgValB),
  .xIn      (xIn),
  .cIn      (cIn),
  .zlIn     (zlIn),
  .fOut     (fOut),
  .oOut     (oOut)
);

// File: tb/tb_esop_fault_inject.sv
module tb_esop_fault_inject;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgKind = '0;
  logic [3:0] cfgLineA = '0;
  logic [3:0] cfgLineB = '0;
  logic       cfgValA = 1'b0;
  logic       cfgValB = 1'b0;
  logic [2:0] xIn = '0;
  logic [2:0] cIn = '0;
  logic       zlIn = 1'b0;
  logic       fOut;
  logic       oOut;

  always #2 clk = ~clk;

  esop_fault_inject dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgLineA(cfgLineA), .cfgLineB(cfgLineB), .cfgValA(cfgValA), .cfgValB(cfgValB),
    .xIn(xIn), .cIn(cIn), .zlIn(zlIn), .fOut(fOut), .oOut(oOut)
  );

  typedef struct {
    logic  f;
    logic  o;
    string tag;
  } expT;

  expT q[$];
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // Bench's view of the loaded configuration
  logic [2:0] mKind = '0;
  logic [3:0] mA = '0;
  logic [3:0] mB = '0;
  logic       mVA = 1'b0;
  logic       mVB = 1'b0;

  function automatic logic gateOf(input int i, input logic [11:0] l);
    case (i)
      7:  return l[0] & l[4];
      8:  return l[0] & l[1] & l[5];
      9:  return l[1] & l[2] & l[4] & l[6];
      10: return l[7] ^ l[8];
      default: return l[9] ^ l[10];
    endcase
  endfunction

  // Returns {F, O} for inputs in = {zl, c3..c1, x3..x1}
  function automatic logic [1:0] model(input logic [6:0] in);
    logic [11:0] fl;
    logic [11:0] lv;
    logic        br;
    fl = '0;
    lv = '0;
    for (int i = 0; i < 12; i++) fl[i] = (i < 7) ? in[i] : gateOf(i, fl);
    br = 1'b0;
    if (mA < 12 && mB < 12)
      br = (mKind == 3'd4) ? (fl[mA] | fl[mB]) : (fl[mA] & fl[mB]);
    for (int i = 0; i < 12; i++) begin
      logic v;
      v = (i < 7) ? in[i] : gateOf(i, lv);
      if (mKind == 3'd1 && mA == 4'(i)) v = mVA;
      else if (mKind == 3'd2 && mA == 4'(i)) v = mVA;
      else if (mKind == 3'd2 && mB == 4'(i)) v = mVB;
      else if ((mKind == 3'd3 || mKind == 3'd4) && mA < 12 && mB < 12
               && (mA == 4'(i) || mB == 4'(i))) v = br;
      lv[i] = v;
    end
    return {lv[11], ^lv[6:0]};
  endfunction

  task automatic applyVec(input logic [6:0] v, input string tag);
    expT e;
    logic [1:0] r;
    @(negedge clk);
    xIn  = v[2:0];
    cIn  = v[5:3];
    zlIn = v[6];
    r = model(v);
    e.f = r[1];
    e.o = r[0];
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic writeCfg(input logic [2:0] k, input logic [3:0] a, input logic [3:0] b,
                          input logic va, input logic vb, input logic we);
    @(negedge clk);
    cfgKind = k; cfgLineA = a; cfgLineB = b; cfgValA = va; cfgValB = vb; cfgWe = we;
    @(negedge clk);
    cfgWe = 1'b0;
    if (we) begin
      mKind = k; mA = a; mB = b; mVA = va; mVB = vb;
    end
  endtask

  task automatic allVecs(input string tag);
    for (int v = 0; v < 128; v++) applyVec(7'(v), tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mKind = '0; mA = '0; mB = '0; mVA = 1'b0; mVB = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        checks++;
        if (fOut !== e.f || oOut !== e.o) begin
          failures++;
          $display("FAIL %s: F/O actual=%b%b expected=%b%b", e.tag, fOut, oOut, e.f, e.o);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state is fault-free
    allVecs("R1");

    // R2 R4 R8: every single stuck-at; B fields set opposite to show they are ignored
    for (int a = 0; a < 12; a++)
      for (int s = 0; s < 2; s++) begin
        writeCfg(3'd1, 4'(a), 4'(11 - a), s[0], ~s[0], 1'b1);
        allVecs("R4 R2 R8");
      end

    // R5 R8: every double stuck-at
    for (int a = 0; a < 12; a++)
      for (int b = a + 1; b < 12; b++)
        for (int p = 0; p < 4; p++) begin
          writeCfg(3'd2, 4'(a), 4'(b), p[1], p[0], 1'b1);
          allVecs("R5 R8");
        end
    // R5 equal indices: value A wins
    writeCfg(3'd2, 4'd11, 4'd11, 1'b1, 1'b0, 1'b1); allVecs("R5");
    writeCfg(3'd2, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1);   allVecs("R5");

    // R6 R7 R8: every bridge pair
    for (int a = 0; a < 12; a++)
      for (int b = a + 1; b < 12; b++) begin
        writeCfg(3'd3, 4'(a), 4'(b), 1'b0, 1'b0, 1'b1); allVecs("R6 R8");
        writeCfg(3'd4, 4'(b), 4'(a), 1'b1, 1'b1, 1'b1); allVecs("R7 R8");
      end

    // R3 spare codes behave as no fault
    for (int k = 5; k < 8; k++) begin
      writeCfg(3'(k), 4'd11, 4'd0, 1'b1, 1'b1, 1'b1);
      allVecs("R3");
    end

    // R10 out-of-range indices
    for (int a = 12; a < 16; a++) begin
      writeCfg(3'd1, 4'(a), 4'd11, 1'b1, 1'b1, 1'b1); allVecs("R10");
    end
    writeCfg(3'd2, 4'd13, 4'd11, 1'b1, 1'b0, 1'b1); allVecs("R10");
    writeCfg(3'd3, 4'd14, 4'd11, 1'b0, 1'b0, 1'b1); allVecs("R10");
    writeCfg(3'd4, 4'd5, 4'd15, 1'b0, 1'b0, 1'b1);  allVecs("R10");

    // R9 field change without write enable is ignored
    writeCfg(3'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1);
    writeCfg(3'd1, 4'd11, 4'd0, 1'b1, 1'b0, 1'b0);
    allVecs("R9");
    // R9 reset clears a loaded fault
    writeCfg(3'd1, 4'd11, 4'd0, 1'b1, 1'b0, 1'b1);
    allVecs("R9");
    doReset();
    allVecs("R9");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule